// File: doc/BRIEF.md
# Receive Frame Statistics Counters with Threshold Interrupts

This block keeps four receive statistics counters for an Ethernet MAC: all frames (good or bad), frames with a CRC error, frames with an alignment error, and good unicast frames. The frame parser pulses one event input for each counter, and one frame may pulse several at once. Every counter watches two points on its scale: the half-scale value and the all-ones value. When a counter reaches either point, it latches a raw interrupt flag.

Software reads the counters and a 32-bit raw status word over a simple register port with byte enables. A read of a counter that includes byte lane [7:0] clears that counter's flag. A control bit chooses what happens at the top of the scale: either the counter wraps to zero, or it stays pinned at all-ones and keeps raising its flag.

Top module: `rxstat_irq_bank`

## Requirements
- R1: A synchronous active-high reset clears every counter, every status flag and the stop-rollover control bit. After reset, every register reads zero.
- R2: Each counter rises by exactly one in every cycle its event input is high and holds its value otherwise. Events for different counters in the same cycle each take effect.
- R3: A counter's flag is set on the increment that brings it to half scale (bit CNT_W-1 alone set, 0x8000 for 16 bits, 0x80000000 for 32 bits).
- R4: A counter's flag is set on the increment that brings it to all-ones.
- R5: With the stop-rollover bit clear, an event at all-ones wraps the counter to zero. That wrap does not set the flag.
- R6: With the stop-rollover bit set, an event at all-ones leaves the counter at all-ones and sets its flag again.
- R7: A read of a counter's own address with bus_be[0] high clears its flag. A read with bus_be[0] low leaves the flag unchanged.
- R8: If a flag-setting increment and a clearing read of the same counter fall in one cycle, the flag ends up set.
- R9: The status word at 0x104 shows the flags at these positions: all-frames at bit 0, CRC error at bit 5, alignment error at bit 6, good unicast at bit 17. Every other bit reads zero.
- R10: Writes to the status word and to the counter addresses change nothing. A write to the control word at 0x100 with bus_be[0] high loads bit 0 as the stop-rollover bit.
- R11: Read data appears on bus_rdata one cycle after the read. It holds the register value as it was when the read was issued, with counters zero-extended. bus_rdata is zero after any cycle without a read or with a read of an unmapped address. The counter addresses are 0x180 (all frames), 0x190 (CRC), 0x194 (alignment) and 0x1C4 (good unicast).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_any | input | 1 | One-cycle pulse: a frame was received, good or bad |
| ev_crc | input | 1 | One-cycle pulse: frame with CRC error |
| ev_align | input | 1 | One-cycle pulse: frame with alignment error |
| ev_ucast | input | 1 | One-cycle pulse: good unicast frame |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |

## Verification
The hardest states to reach from the ports are the top of a counter's scale, and the cycle where a threshold increment meets a clearing read. Counting to the top takes about 2^CNT_W event pulses. The bench therefore builds the 16-bit variant and drives every counter's event line until each counter stands just below the threshold. Only then does it issue the deciding increment. It pairs that increment with a clearing read, a read without the low byte lane, a wrap step and a pinned step, then reads the status word at each point.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
    localparam int unsigned NCNT   = 4;
    localparam int unsigned DATA_W = 32;

    // counter index order
    localparam int unsigned IX_ANY   = 0;
    localparam int unsigned IX_CRC   = 1;
    localparam int unsigned IX_ALIGN = 2;
    localparam int unsigned IX_UCAST = 3;

    localparam logic [11:0] A_CTRL = 12'h100;
    localparam logic [11:0] A_STAT = 12'h104;

    function automatic logic [11:0] cnt_addr(input int unsigned ix);
        case (ix)
            0:       return 12'h180;
            1:       return 12'h190;
            2:       return 12'h194;
            default: return 12'h1C4;
        endcase
    endfunction

    function automatic int unsigned stat_pos(input int unsigned ix);
        case (ix)
            0:       return 0;
            1:       return 5;
            2:       return 6;
            default: return 17;
        endcase
    endfunction
endpackage

// File: rtl/rxstat_cnt.sv
module rxstat_cnt #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             pin_top,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             flg;
    } st_t;

    st_t s_d, s_q;
    logic at_top;
    logic hit;

    always_comb begin
        s_d    = s_q;
        at_top = (s_q.val == TOP);
        hit    = 1'b0;
        if (inc) begin
            if (at_top) begin
                if (pin_top) begin
                    s_d.val = TOP;
                    hit     = 1'b1;
                end else begin
                    s_d.val = '0;
                end
            end else begin
                s_d.val = s_q.val + 1'b1;
                hit     = (s_d.val == HALF) || (s_d.val == TOP);
            end
        end
        // a threshold hit outranks a clearing read
        s_d.flg = hit | (s_q.flg & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign count = s_q.val;
    assign flag  = s_q.flg;
endmodule

// File: rtl/rxstat_decode.sv
module rxstat_decode
    import rxstat_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output logic [NCNT-1:0]   cnt_rd,
    output logic [NCNT-1:0]   cnt_clr,
    output logic              stat_rd,
    output logic              ctrl_rd,
    output logic              ctrl_wr
);
    logic rd, wr;

    always_comb begin
        rd      = en & ~we;
        wr      = en & we;
        stat_rd = rd & (addr == ADDR_W'(A_STAT));
        ctrl_rd = rd & (addr == ADDR_W'(A_CTRL));
        ctrl_wr = wr & (addr == ADDR_W'(A_CTRL)) & be[0];
        for (int unsigned i = 0; i < NCNT; i++) begin
            cnt_rd[i]  = rd & (addr == ADDR_W'(cnt_addr(i)));
            cnt_clr[i] = cnt_rd[i] & be[0];
        end
    end
endmodule

// File: rtl/rxstat_irq_bank.sv
module rxstat_irq_bank
    import rxstat_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_any,
    input  logic              ev_crc,
    input  logic              ev_align,
    input  logic              ev_ucast,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              pin;
    } top_t;

    top_t t_d, t_q;

    logic [NCNT-1:0]            ev_vec;
    logic [NCNT-1:0]            cnt_rd, cnt_clr, flags;
    logic [NCNT-1:0][CNT_W-1:0] cnt_vec;
    logic                       stat_rd, ctrl_rd, ctrl_wr;
    logic [DATA_W-1:0]          stat_word;

    assign ev_vec[IX_ANY]   = ev_any;
    assign ev_vec[IX_CRC]   = ev_crc;
    assign ev_vec[IX_ALIGN] = ev_align;
    assign ev_vec[IX_UCAST] = ev_ucast;

    rxstat_decode #(.ADDR_W(ADDR_W)) u_dec (
        .en      (bus_en),
        .we      (bus_we),
        .addr    (bus_addr),
        .be      (bus_be),
        .cnt_rd  (cnt_rd),
        .cnt_clr (cnt_clr),
        .stat_rd (stat_rd),
        .ctrl_rd (ctrl_rd),
        .ctrl_wr (ctrl_wr)
    );

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        rxstat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc     (ev_vec[g]),
            .pin_top (t_q.pin),
            .clr     (cnt_clr[g]),
            .count   (cnt_vec[g]),
            .flag    (flags[g])
        );
    end

    always_comb begin
        stat_word = '0;
        for (int unsigned i = 0; i < NCNT; i++)
            stat_word[stat_pos(i)] = flags[i];
    end

    always_comb begin
        t_d       = t_q;
        t_d.rdata = '0;
        if (stat_rd) t_d.rdata = stat_word;
        if (ctrl_rd) t_d.rdata[0] = t_q.pin;
        for (int unsigned i = 0; i < NCNT; i++)
            if (cnt_rd[i]) t_d.rdata[CNT_W-1:0] = cnt_vec[i];
        if (ctrl_wr) t_d.pin = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign bus_rdata = t_q.rdata;
endmodule

// File: rtl/rxstat_checker.sv
module rxstat_checker
    import rxstat_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NCNT-1:0]            ev_vec,
    input logic                       bus_en,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [3:0]                 bus_be,
    input logic [31:0]                bus_rdata,
    input logic [NCNT-1:0][CNT_W-1:0] cnt_vec,
    input logic [NCNT-1:0]            flags,
    input logic                       pin
);
    localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (flags == '0 && pin == 1'b0)); // R1
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !bus_we) |=> bus_rdata == '0); // R11

    for (genvar g = 0; g < NCNT; g++) begin : g_chk
        logic clr_g;
        assign clr_g = bus_en && !bus_we && bus_be[0] && (bus_addr == ADDR_W'(cnt_addr(g)));

        AST_NO_EVENT_STABLE: assert property (@(posedge clk) disable iff (rst)
            !ev_vec[g] |=> $stable(cnt_vec[g])); // R2
        AST_HALF_FLAG: assert property (@(posedge clk) disable iff (rst)
            (ev_vec[g] && cnt_vec[g] == HALF - 1'b1) |=> (flags[g] && cnt_vec[g] == HALF)); // R3
        AST_TOP_FLAG: assert property (@(posedge clk) disable iff (rst)
            (ev_vec[g] && cnt_vec[g] == TOP - 1'b1) |=> (flags[g] && cnt_vec[g] == TOP)); // R4
        AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
            (ev_vec[g] && cnt_vec[g] == TOP && !pin) |=> cnt_vec[g] == '0); // R5
        AST_PIN_TOP: assert property (@(posedge clk) disable iff (rst)
            (ev_vec[g] && cnt_vec[g] == TOP && pin) |=> (cnt_vec[g] == TOP && flags[g])); // R6
        AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
            (clr_g && !ev_vec[g]) |=> !flags[g]); // R7
        AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst)
            (flags[g] && !clr_g) |=> flags[g]); // R7
    end
endmodule

bind rxstat_irq_bank rxstat_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_vec    (ev_vec),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .cnt_vec   (cnt_vec),
    .flags     (flags),
    .pin       (t_q.pin)
);

// File: tb/sim_rxstat_irq_bank.sv
`timescale 1ns/1ps
module sim_rxstat_irq_bank;
    localparam int unsigned W    = 16;
    localparam int unsigned LIM  = 190000;
    localparam logic [W-1:0] HALF = 16'h8000;
    localparam logic [W-1:0] TOP  = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  ev;
    logic        en, we;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    logic [W-1:0] m_cnt [4];
    logic         m_flg [4];
    logic         m_pin;

    always #10 clk = ~clk;

    rxstat_irq_bank #(.CNT_W(W), .ADDR_W(12)) u0 (
        .clk(clk), .rst(rst),
        .ev_any(ev[0]), .ev_crc(ev[1]), .ev_align(ev[2]), .ev_ucast(ev[3]),
        .bus_en(en), .bus_we(we), .bus_addr(addr), .bus_be(be),
        .bus_wdata(wd), .bus_rdata(rdata)
    );

    function automatic logic [11:0] caddr(input int i);
        case (i)
            0: return 12'h180;
            1: return 12'h190;
            2: return 12'h194;
            default: return 12'h1C4;
        endcase
    endfunction

    function automatic logic [31:0] stat_exp();
        logic [31:0] s = '0;
        s[0]  = m_flg[0];
        s[5]  = m_flg[1];
        s[6]  = m_flg[2];
        s[17] = m_flg[3];
        return s;
    endfunction

    function automatic logic [31:0] read_exp(input logic e, input logic w, input logic [11:0] a);
        logic [31:0] r = '0;
        if (e && !w) begin
            if (a == 12'h104) r = stat_exp();
            else if (a == 12'h100) r[0] = m_pin;
            else for (int i = 0; i < 4; i++) if (a == caddr(i)) r[W-1:0] = m_cnt[i];
        end
        return r;
    endfunction

    function automatic void model_step(input logic [3:0] e4, input logic e, input logic w,
                                       input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
        for (int i = 0; i < 4; i++) begin
            logic clr, hit;
            clr = e && !w && b[0] && (a == caddr(i));
            hit = 1'b0;
            if (e4[i]) begin
                if (m_cnt[i] == TOP) begin
                    if (m_pin) hit = 1'b1;
                    else m_cnt[i] = '0;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1'b1;
                    hit = (m_cnt[i] == HALF) || (m_cnt[i] == TOP);
                end
            end
            m_flg[i] = hit | (m_flg[i] & ~clr);
        end
        if (e && w && b[0] && a == 12'h100) m_pin = d[0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] e4, input logic e, input logic w, input logic [11:0] a,
                       input logic [3:0] b, input logic [31:0] d, input string tag);
        logic [31:0] exp;
        string t;
        @(negedge clk);
        ev = e4; en = e; we = w; addr = a; be = b; wd = d;
        exp = read_exp(e, w, a);
        @(posedge clk);
        model_step(e4, e, w, a, b, d);
        #2;
        t = tag;
        if (t == "") t = (e && !w && a == 12'h104) ? "R9" : (e && !w) ? "R2" : "R11";
        check(t, rdata, exp);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(4'h0, 1'b1, 1'b0, a, 4'hF, '0, tag);
    endtask

    // drive each counter's event until it reaches the target
    task automatic fill(input logic [W-1:0] tgt);
        bit busy = 1;
        while (busy) begin
            logic [3:0] e4;
            for (int i = 0; i < 4; i++) e4[i] = (m_cnt[i] < tgt);
            busy = (e4 != 4'h0);
            if (busy) cyc(e4, 1'b0, 1'b0, '0, '0, '0, "R2");
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > LIM) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIM);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [11:0] alist [7];
        void'($urandom(32'h5EED_1234));
        alist = '{12'h180, 12'h190, 12'h194, 12'h1C4, 12'h104, 12'h100, 12'h108};
        ev = '0; en = 0; we = 0; addr = '0; be = '0; wd = '0;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin m_cnt[i] = '0; m_flg[i] = 1'b0; end
        m_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: everything reads zero after reset
        for (int i = 0; i < 4; i++) rd(caddr(i), "R1");
        rd(12'h104, "R1");
        rd(12'h100, "R1");

        // R10: writes to status and counters have no effect
        cyc(4'h0, 1, 1, 12'h104, 4'hF, 32'hFFFF_FFFF, "R10");
        cyc(4'h0, 1, 1, 12'h180, 4'hF, 32'h0000_1234, "R10");
        rd(12'h180, "R10");
        rd(12'h104, "R10");

        // R2: several counters on one pulse
        cyc(4'b0011, 0, 0, '0, '0, '0, "R2");
        cyc(4'b1111, 0, 0, '0, '0, '0, "R2");
        for (int i = 0; i < 4; i++) rd(caddr(i), "R2");

        // random mix, stop-rollover kept clear
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] e4;
            logic e, w;
            logic [11:0] a;
            e4 = 4'($urandom);
            e  = ($urandom % 2) == 0;
            w  = ($urandom % 4) == 0;
            a  = alist[$urandom % 7];
            cyc(e4, e, w, a, 4'($urandom), {31'($urandom), 1'b0}, "");
        end

        // R3 + R8: half scale reached while clearing-reading the CRC counter
        for (int i = 0; i < 4; i++) rd(caddr(i), "R7");
        fill(HALF - 1'b1);
        cyc(4'hF, 1, 0, 12'h190, 4'h1, '0, "R8");
        rd(12'h104, "R3");
        check("R3", rdata, 32'h0002_0061);

        // R7: read without low lane keeps flag; with it clears
        cyc(4'h0, 1, 0, 12'h180, 4'hE, '0, "R7");
        rd(12'h104, "R7");
        cyc(4'h0, 1, 0, 12'h180, 4'h1, '0, "R7");
        rd(12'h104, "R7");
        check("R7", rdata, 32'h0002_0060);
        for (int i = 1; i < 4; i++) rd(caddr(i), "R7");

        // R4: full scale
        fill(TOP - 1'b1);
        rd(12'h104, "R4");
        cyc(4'hF, 0, 0, '0, '0, '0, "R4");
        rd(12'h104, "R4");
        check("R4", rdata, 32'h0002_0061);
        rd(12'h180, "R4");
        check("R4", rdata, 32'h0000_FFFF);

        // R5: wrap with flag cleared first
        rd(12'h194, "R5");
        cyc(4'b0100, 0, 0, '0, '0, '0, "R5");
        rd(12'h194, "R5");
        check("R5", rdata, 32'h0);
        rd(12'h104, "R5");

        // R6: pin at top, flag raised again
        cyc(4'h0, 1, 1, 12'h100, 4'h1, 32'h1, "R10");
        rd(12'h100, "R10");
        check("R10", rdata, 32'h1);
        rd(12'h190, "R6");
        cyc(4'b0010, 0, 0, '0, '0, '0, "R6");
        rd(12'h190, "R6");
        check("R6", rdata, 32'h0000_FFFF);
        rd(12'h104, "R6");

        // R11: unmapped read returns zero
        rd(12'h108, "R11");
        check("R11", rdata, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule